// File: doc/BRIEF.md
# Hardware Function Call Stack Engine

This block gives a hardware thread that is built as a state machine a call stack in the style of software. The stack lives in a local RAM that is addressed by 32-bit word. The user logic issues one command at a time. There are eight commands: push or pop a word, call a function, return from one, reserve local variables, read or write a local variable by its index, and ask for the global byte address of a local variable. The engine keeps a stack pointer and a frame pointer as word addresses. Instead of a program counter it stores the caller's 16-bit return-state code, so recursive calls unwind in the correct order.

A frame starts at the frame pointer and holds, from the lowest word upward: the saved frame pointer of the caller, the argument count, and the return-state code. The local variables follow. Local variable k therefore lives at word fp+3+k. The caller pushes arguments before it calls. CALL lifts those arguments three words higher and writes the frame header in the space they used. The callee can then collect its arguments with POP, the last one pushed coming first. RETURN sets the stack pointer back to the callee's frame pointer. That releases both the frame and its argument slots. RETURN also restores the caller's frame pointer and hands back the saved return-state code together with a 32-bit return value. A function code with bit 15 set is a system-call stub: the engine flags it and returns at once without touching the stack.

The controller is one state machine:
- IDLE accepts a command.
- MV_RD and MV_WR move one argument per pass.
- HDR_FP, HDR_CNT and HDR_RS write the three header words.
- RT_FP and RT_RS read back the saved frame pointer and the return state.
- RD_WAIT covers the RAM read latency for POP and READ.
- FIN presents the result for one cycle.

The transitions are:
- IDLE goes to MV_RD when a call has arguments, to HDR_FP when it has none, to RT_FP on a return, to RD_WAIT on a pop or read, and to FIN otherwise.
- MV_WR goes back to MV_RD until the last argument has moved, then to HDR_FP.
- The header states run HDR_FP, HDR_CNT, HDR_RS, FIN.
- The return states run RT_FP, RT_RS, FIN.
- RD_WAIT goes to FIN, and FIN goes to IDLE.

Top module: `callstack_engine`

## Requirements
- R1: After reset, cmd_ready is 1 and done is 0. The frame pointer is 0 and the stack pointer is 3, so ADDRESSOF of index 0 returns BASE_ADDR+12.
- R2: PUSH stores cmd_data at the top of the stack. POP returns the most recently pushed word that has not yet been popped, in done_data.
- R3: DECLARE n advances the stack pointer by n words. WRITE stores cmd_data in the variable at cmd_index (word fp+3+index). READ returns that variable in done_data.
- R4: ADDRESSOF returns BASE_ADDR + 4*(fp+3+cmd_index) in done_data.
- R5: A CALL with cmd_func bit 15 clear and cmd_data=n arguments reports done_state=cmd_func. The new frame pointer equals the old stack pointer minus n. The arguments are then returned by POP, last pushed first.
- R6: RETURN reports the saved return state in done_state and cmd_data in done_data. It restores the caller's frame pointer and sets the stack pointer to the callee's frame pointer, the caller's stack pointer before it pushed the arguments.
- R7: Nested calls unwind in LIFO order: each RETURN reports the return state of the most recent unfinished CALL.
- R8: A PUSH, DECLARE or user CALL that would take the stack pointer above HEAP_START is refused. The engine reports done_ovf=1 with done_state=0 and done_data=0, and changes no pointer or memory word. A stack pointer equal to HEAP_START is still allowed.
- R9: A CALL with cmd_func bit 15 set reports done_sys=1 and done_state=cmd_ret, and leaves both pointers unchanged.
- R10: Command encoding on cmd_op:
  - 0 = CALL
  - 1 = RETURN
  - 2 = PUSH
  - 3 = POP
  - 4 = DECLARE
  - 5 = READ
  - 6 = WRITE
  - 7 = ADDRESSOF

  A command is accepted when cmd_valid and cmd_ready are both 1. cmd_ready is 1 only in IDLE. Each command produces exactly one done pulse, one cycle wide. On that pulse, done_state and done_data are 0 wherever R4 to R9 give them no value, and so are done_ovf and done_sys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op | input | 3 | Command code (R10) |
| cmd_data | input | 32 | Push/write value, declare count, argument count, or return value |
| cmd_index | input | 16 | Local variable index |
| cmd_func | input | 16 | Function code for CALL; bit 15 marks a system-call stub |
| cmd_ret | input | 16 | Caller's return-state code for CALL |
| done | output | 1 | One-cycle completion pulse |
| done_state | output | 16 | Callee start state or restored return state |
| done_data | output | 32 | Popped/read word, address, or return value |
| done_ovf | output | 1 | Command refused: stack would enter the heap |
| done_sys | output | 1 | System-call stub taken |

## Verification
The hardest state to reach is two frames deep, with arguments moved over the header slots and a local variable written in the outer callee. Only in that state do a wrong header layout, a wrong relocation order or a wrong unwind show up at the ports. The stimulus pushes two arguments and calls, then pops and declares in the callee. It then pushes one more argument and recurses. It unwinds with two RETURNs and reads back the outer local and the root's locals after each one. A final POP after each unwind exposes the exact restored stack pointer. The heap boundary is reached by one large DECLARE. The next PUSH lands on the last legal word and the one after it is refused.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [2:0] {
        OP_CALL    = 3'd0,
        OP_RETURN  = 3'd1,
        OP_PUSH    = 3'd2,
        OP_POP     = 3'd3,
        OP_DECLARE = 3'd4,
        OP_READ    = 3'd5,
        OP_WRITE   = 3'd6,
        OP_ADDROF  = 3'd7
    } op_e;

    // saved fp, argument count, return state
    localparam int HDR_WORDS = 3;
    localparam int SYS_BIT   = 15;
endpackage

// File: rtl/cs_ram.sv
module cs_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wd;
        end
        rd <= mem[addr];
    end
endmodule

// File: rtl/cs_addr.sv
module cs_addr
    import cs_pkg::*;
#(
    parameter int          ADDR_W     = 7,
    parameter int          HEAP_START = 64,
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] fp,
    input  logic [15:0]       index,
    input  logic [31:0]       amount,
    output logic [ADDR_W-1:0] var_word,
    output logic [31:0]       var_byte,
    output logic              ovf_push,
    output logic              ovf_grow,
    output logic              ovf_frame
);
    localparam int PAD32 = 32 - ADDR_W;
    localparam int PAD33 = 33 - ADDR_W;

    logic [31:0] word_ix;
    logic [32:0] sp_w;
    logic [32:0] limit;

    assign word_ix  = {{PAD32{1'b0}}, fp} + 32'(HDR_WORDS) + {16'd0, index};
    assign var_word = word_ix[ADDR_W-1:0];
    assign var_byte = BASE_ADDR + (word_ix << 2);

    assign sp_w      = {{PAD33{1'b0}}, sp};
    assign limit     = 33'(HEAP_START);
    assign ovf_push  = (sp_w + 33'd1) > limit;
    assign ovf_grow  = (sp_w + {1'b0, amount}) > limit;
    assign ovf_frame = (sp_w + 33'(HDR_WORDS)) > limit;
endmodule

// File: rtl/callstack_engine.sv
module callstack_engine
    import cs_pkg::*;
#(
    parameter int          ADDR_W     = 7,
    parameter int          HEAP_START = 64,
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [2:0]  cmd_op,
    input  logic [31:0] cmd_data,
    input  logic [15:0] cmd_index,
    input  logic [15:0] cmd_func,
    input  logic [15:0] cmd_ret,
    output logic        done,
    output logic [15:0] done_state,
    output logic [31:0] done_data,
    output logic        done_ovf,
    output logic        done_sys
);
    localparam int                PADW = 32 - ADDR_W;
    localparam logic [ADDR_W-1:0] HDR  = ADDR_W'(HDR_WORDS);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

    typedef enum logic [3:0] {
        S_IDLE, S_MV_RD, S_MV_WR, S_HDR_FP, S_HDR_CNT, S_HDR_RS,
        S_RT_FP, S_RT_RS, S_RD_WAIT, S_FIN
    } state_e;

    state_e state, nstate;

    logic [ADDR_W-1:0] sp, fp, base_q, k_q, cnt_q, sfp_q;
    logic [15:0]       ret_q, func_q, res_state;
    logic [31:0]       rv_q, res_data;
    logic              res_ovf, res_sys;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [31:0]       ram_wd, ram_rd;

    logic [ADDR_W-1:0] var_word;
    logic [31:0]       var_byte;
    logic              ovf_push, ovf_grow, ovf_frame;

    op_e               op;
    logic              accept, is_sys, refused;
    logic [ADDR_W-1:0] n_arg;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && (state == S_IDLE);
    assign is_sys = cmd_func[SYS_BIT];
    assign n_arg  = cmd_data[ADDR_W-1:0];
    assign refused = (op == OP_PUSH && ovf_push) || (op == OP_DECLARE && ovf_grow)
                   || (op == OP_CALL && !is_sys && ovf_frame);

    cs_ram #(.ADDR_W(ADDR_W), .DATA_W(32)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wd(ram_wd), .rd(ram_rd)
    );

    cs_addr #(.ADDR_W(ADDR_W), .HEAP_START(HEAP_START), .BASE_ADDR(BASE_ADDR)) u_addr (
        .sp(sp), .fp(fp), .index(cmd_index), .amount(cmd_data),
        .var_word(var_word), .var_byte(var_byte),
        .ovf_push(ovf_push), .ovf_grow(ovf_grow), .ovf_frame(ovf_frame)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_CALL: begin
                            if (is_sys || ovf_frame) nstate = S_FIN;
                            else if (cmd_data != 32'd0) nstate = S_MV_RD;
                            else nstate = S_HDR_FP;
                        end
                        OP_RETURN:        nstate = S_RT_FP;
                        OP_POP, OP_READ:  nstate = S_RD_WAIT;
                        default:          nstate = S_FIN;
                    endcase
                end
            end
            S_MV_RD:   nstate = S_MV_WR;
            S_MV_WR:   nstate = (k_q == '0) ? S_HDR_FP : S_MV_RD;
            S_HDR_FP:  nstate = S_HDR_CNT;
            S_HDR_CNT: nstate = S_HDR_RS;
            S_HDR_RS:  nstate = S_FIN;
            S_RT_FP:   nstate = S_RT_RS;
            S_RT_RS:   nstate = S_FIN;
            S_RD_WAIT: nstate = S_FIN;
            S_FIN:     nstate = S_IDLE;
            default:   nstate = S_IDLE;
        endcase
    end

    // RAM sequencing
    always_comb begin
        ram_we   = 1'b0;
        ram_addr = '0;
        ram_wd   = '0;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_PUSH: begin
                            ram_we   = !ovf_push;
                            ram_addr = sp;
                            ram_wd   = cmd_data;
                        end
                        OP_POP:    ram_addr = sp - ONE;
                        OP_READ:   ram_addr = var_word;
                        OP_WRITE: begin
                            ram_we   = 1'b1;
                            ram_addr = var_word;
                            ram_wd   = cmd_data;
                        end
                        OP_RETURN: ram_addr = fp;
                        default:   ram_addr = '0;
                    endcase
                end
            end
            S_MV_RD: ram_addr = base_q + k_q;
            S_MV_WR: begin
                ram_we   = 1'b1;
                ram_addr = base_q + k_q + HDR;
                ram_wd   = ram_rd;
            end
            S_HDR_FP: begin
                ram_we   = 1'b1;
                ram_addr = base_q;
                ram_wd   = {{PADW{1'b0}}, fp};
            end
            S_HDR_CNT: begin
                ram_we   = 1'b1;
                ram_addr = base_q + ONE;
                ram_wd   = {{PADW{1'b0}}, cnt_q};
            end
            S_HDR_RS: begin
                ram_we   = 1'b1;
                ram_addr = base_q + ONE + ONE;
                ram_wd   = {16'd0, ret_q};
            end
            S_RT_FP: ram_addr = fp + ONE + ONE;
            default: ram_addr = '0;
        endcase
    end

    // Pointers and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp        <= HDR;   // R1: root frame header reserved
            fp        <= '0;
            base_q    <= '0;
            k_q       <= '0;
            cnt_q     <= '0;
            sfp_q     <= '0;
            ret_q     <= '0;
            func_q    <= '0;
            rv_q      <= '0;
            res_state <= '0;
            res_data  <= '0;
            res_ovf   <= 1'b0;
            res_sys   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        res_state <= '0;
                        res_data  <= '0;
                        res_ovf   <= 1'b0;
                        res_sys   <= 1'b0;
                        cnt_q     <= n_arg;
                        ret_q     <= cmd_ret;
                        func_q    <= cmd_func;
                        rv_q      <= cmd_data;
                        base_q    <= sp - n_arg;
                        k_q       <= n_arg - ONE;
                        unique case (op)
                            OP_CALL: begin
                                if (is_sys) begin
                                    res_sys   <= 1'b1;
                                    res_state <= cmd_ret;
                                end else if (ovf_frame) begin
                                    res_ovf <= 1'b1;
                                end
                            end
                            OP_PUSH: begin
                                if (ovf_push) res_ovf <= 1'b1;
                                else          sp <= sp + ONE;
                            end
                            OP_POP: sp <= sp - ONE;
                            OP_DECLARE: begin
                                if (ovf_grow) res_ovf <= 1'b1;
                                else          sp <= sp + n_arg;
                            end
                            OP_ADDROF: res_data <= var_byte;
                            default: ;
                        endcase
                    end
                end
                S_MV_WR: if (k_q != '0) k_q <= k_q - ONE;
                S_HDR_RS: begin
                    fp        <= base_q;
                    sp        <= sp + HDR;
                    res_state <= func_q;
                end
                S_RT_FP: sfp_q <= ram_rd[ADDR_W-1:0];
                S_RT_RS: begin
                    res_state <= ram_rd[15:0];
                    res_data  <= rv_q;
                    sp        <= fp;
                    fp        <= sfp_q;
                end
                S_RD_WAIT: res_data <= ram_rd;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_ready  = (state == S_IDLE);
        done       = (state == S_FIN);
        done_state = res_state;
        done_data  = res_data;
        done_ovf   = res_ovf;
        done_sys   = res_sys;
    end

    AST_HEAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sp) <= 32'(HEAP_START)); // R8
    AST_NO_HEAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> 32'(ram_addr) < 32'(HEAP_START)); // R8
    AST_REFUSED_KEEPS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && refused) |=> (sp == $past(sp) && fp == $past(fp))); // R8
    AST_FRAME_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fp) + 32'(HDR_WORDS) <= 32'(sp)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready)); // R10
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, cmd_ready})); // R10
endmodule

// File: tb/callstack_engine_test.sv
module callstack_engine_test;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [2:0] C_CALL = 3'd0, C_RET = 3'd1, C_PUSH = 3'd2, C_POP = 3'd3,
                           C_DECL = 3'd4, C_READ = 3'd5, C_WRITE = 3'd6, C_ADDR = 3'd7;

    typedef struct packed {
        logic [15:0] st;
        logic [31:0] dat;
        logic        ovf;
        logic        sys;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic [15:0] cmd_index = '0;
    logic [15:0] cmd_func = '0;
    logic [15:0] cmd_ret = '0;
    logic        done;
    logic [15:0] done_state;
    logic [31:0] done_data;
    logic        done_ovf;
    logic        done_sys;

    int checks = 0;
    int errors = 0;
    exp_t  sb[$];
    string tags[$];

    always #2 clk = ~clk;

    callstack_engine #(.ADDR_W(7), .HEAP_START(64), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_index(cmd_index),
        .cmd_func(cmd_func), .cmd_ret(cmd_ret), .done(done),
        .done_state(done_state), .done_data(done_data),
        .done_ovf(done_ovf), .done_sys(done_sys)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected done", 64'(done_state), 64'd0);
            end else begin
                exp_t  e;
                string t;
                exp_t  a;
                e = sb.pop_front();
                t = tags.pop_front();
                a = '{st: done_state, dat: done_data, ovf: done_ovf, sys: done_sys};
                check(a == e, t, 64'(a), 64'(e));
            end
        end
    end

    // Driver: queues the expected result, then issues the command
    task automatic issue(input logic [2:0] op, input logic [31:0] dat, input logic [15:0] idx,
                         input logic [15:0] func, input logic [15:0] ret,
                         input logic [15:0] est, input logic [31:0] edat,
                         input logic eovf, input logic esys, input string tag);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        sb.push_back('{st: est, dat: edat, ovf: eovf, sys: esys});
        tags.push_back(tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = dat; cmd_index = idx;
        cmd_func = func; cmd_ret = ret;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        check(cmd_ready && !done, {tag, " R10 pulse end"}, 64'({cmd_ready, done}), 64'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !done, "R1 reset ready/done", 64'({cmd_ready, done}), 64'd2);

        issue(C_ADDR, 0, 0, 0, 0, 16'h0, BASE + 32'd12, 0, 0, "R1 R4 root addr idx0");
        issue(C_ADDR, 0, 5, 0, 0, 16'h0, BASE + 32'h20, 0, 0, "R4 root addr idx5");

        issue(C_PUSH, 32'h11, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R2 push a");
        issue(C_PUSH, 32'h22, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R2 push b");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'h22, 0, 0, "R2 pop b");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'h11, 0, 0, "R2 pop a");

        issue(C_DECL, 2, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R3 declare 2");
        issue(C_WRITE, 32'hAAAA, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R3 write v0");
        issue(C_WRITE, 32'hBBBB, 1, 0, 0, 16'h0, 32'h0, 0, 0, "R3 write v1");
        issue(C_READ, 0, 1, 0, 0, 16'h0, 32'hBBBB, 0, 0, "R3 read v1");
        issue(C_READ, 0, 0, 0, 0, 16'h0, 32'hAAAA, 0, 0, "R3 read v0");

        // First call: two arguments at words 5 and 6, frame at 5
        issue(C_PUSH, 32'h111, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R5 push arg1");
        issue(C_PUSH, 32'h222, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R5 push arg2");
        issue(C_CALL, 2, 0, 16'h0042, 16'h0007, 16'h0042, 32'h0, 0, 0, "R5 call start state");
        issue(C_ADDR, 0, 0, 0, 0, 16'h0, BASE + 32'h20, 0, 0, "R5 callee fp=5");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'h222, 0, 0, "R5 pop arg2");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'h111, 0, 0, "R5 pop arg1");
        issue(C_DECL, 1, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R3 callee declare");
        issue(C_WRITE, 32'h5555, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R3 callee write");

        // Recursive call: one argument at word 9, frame at 9
        issue(C_PUSH, 32'h333, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R7 push arg");
        issue(C_CALL, 1, 0, 16'h0042, 16'h0009, 16'h0042, 32'h0, 0, 0, "R7 recursive call");
        issue(C_ADDR, 0, 0, 0, 0, 16'h0, BASE + 32'h30, 0, 0, "R7 inner fp=9");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'h333, 0, 0, "R7 inner pop arg");
        issue(C_RET, 32'hDEAD, 0, 0, 0, 16'h0009, 32'hDEAD, 0, 0, "R6 R7 inner return");
        issue(C_READ, 0, 0, 0, 0, 16'h0, 32'h5555, 0, 0, "R6 outer local intact");
        issue(C_ADDR, 0, 0, 0, 0, 16'h0, BASE + 32'h20, 0, 0, "R6 fp restored to 5");
        issue(C_RET, 32'hBEEF, 0, 0, 0, 16'h0007, 32'hBEEF, 0, 0, "R7 outer return");
        issue(C_READ, 0, 1, 0, 0, 16'h0, 32'hBBBB, 0, 0, "R6 root local v1");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'hBBBB, 0, 0, "R6 sp restored to 5");

        // System-call stub
        issue(C_CALL, 0, 0, 16'h8001, 16'h0033, 16'h0033, 32'h0, 0, 1, "R9 sys call");
        issue(C_ADDR, 0, 0, 0, 0, 16'h0, BASE + 32'd12, 0, 0, "R9 fp unchanged");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'hAAAA, 0, 0, "R9 sp unchanged");

        // Heap boundary (sp = 3, HEAP_START = 64)
        issue(C_DECL, 62, 0, 0, 0, 16'h0, 32'h0, 1, 0, "R8 declare refused");
        issue(C_DECL, 60, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R8 declare to 63");
        issue(C_PUSH, 32'h99, 0, 0, 0, 16'h0, 32'h0, 0, 0, "R8 push to limit");
        issue(C_PUSH, 32'h98, 0, 0, 0, 16'h0, 32'h0, 1, 0, "R8 push refused");
        issue(C_POP, 0, 0, 0, 0, 16'h0, 32'h99, 0, 0, "R8 refused push stored nothing");
        issue(C_CALL, 0, 0, 16'h0010, 16'h0001, 16'h0, 32'h0, 1, 0, "R8 call refused");
        issue(C_ADDR, 0, 0, 0, 0, 16'h0, BASE + 32'd12, 0, 0, "R8 fp unchanged");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule